// File: doc/BRIEF.md
# FIFO-Fed Serial Peripheral Master with Selectable Select and Start Control

This block is a single-slave SPI master for a single data lane. Software pushes 32-bit words into a transmit FIFO; a shift engine sends each word most significant bit first on the serial line. While a word goes out, the word coming back on the input line is collected and pushed into a receive FIFO. The serial clock is derived from the system clock with a programmable even ratio and follows SPI mode 0. The clock idles low, the master launches data while the clock is low, and samples the input on the rising edge.

Chip select and transfer start are each chosen independently as software-driven or FIFO-driven. With FIFO-driven select, the select follows transmit activity. With software select, it follows a register bit. With FIFO-driven start, the engine drains the FIFO whenever data is present. With software start, the engine waits for a strobe and stops again once the FIFO is drained. An interrupt status vector has three level bits and two sticky bits, and an enable mask produces one interrupt line. An abort command flushes both FIFOs, drops the select and restores both watermarks to one.

The shift engine is a three-state machine. IDLE is the state with no word in flight. LOW_PHASE holds the clock low and the current bit on the output. HIGH_PHASE holds the clock high after a sample. The transitions are: IDLE to LOW_PHASE (launch: a word is popped when the run condition holds and the FIFO has data); LOW_PHASE to HIGH_PHASE (sample, after one half period); HIGH_PHASE to LOW_PHASE (next bit, or next word when the run condition holds and data is waiting); HIGH_PHASE to IDLE (word end with no further word to send); and any state to IDLE on abort.

Top module: `spi_fifo_master`

## Requirements
- R1: Each transmit word is sent most significant bit first. Each bit changes only while the serial clock is low and is sampled on the rising edge. The 32 bits read from the input line during that word are pushed into the receive FIFO, with the first sampled bit as the MSB.
- R2: With automatic select (cfg_auto_cs=1), spi_cs_n is low whenever the transmit FIFO holds data or a word is being shifted. It is driven high one cycle after both conditions have ended.
- R3: With manual select (cfg_auto_cs=0), spi_cs_n follows the inverse of the select bit that cs_we/cs_val writes, one cycle after the write takes effect. Bus activity has no effect on it.
- R4: With automatic start, shifting runs while the transmit FIFO holds data. When the FIFO is empty the engine stalls: busy is low and spi_sclk is low.
- R5: With manual start, a non-empty transmit FIFO is not shifted until start_req is pulsed. When the FIFO runs empty at a word boundary the engine stops and waits for a new pulse.
- R6: A received word that arrives while the receive FIFO is full (DEPTH words) is dropped, and status bit 3 (receive overrun) is set.
- R7: The status level bits are defined as follows. Bit 0 is set when tx_level is less than the transmit watermark. Bit 1 is set when rx_level is non-zero. Bit 2 is set when rx_level is at or above the receive watermark. A watermark is written from wm_val by tx_wm_we or rx_wm_we and is 1 after reset.
- R8: A start_req pulse while the engine is idle with an empty transmit FIFO sets status bit 4 (transmit underflow).
- R9: Status bits 3 and 4 stay set until a one is written to the matching irq_clr bit. If a set event and a clear fall in the same cycle, the bit stays set.
- R10: abort_req empties both FIFOs, returns the engine to IDLE, drives spi_cs_n high, clears the manual select bit and sets both watermarks back to 1.
- R11: Each serial clock half period lasts cfg_half_div+1 system clock cycles, so one bit takes 2*(cfg_half_div+1) cycles.
- R12: busy is high from the launch of a word until the last word's final half period has ended, and stays high between back-to-back words.
- R13: irq is high exactly when some status bit and its irq_en bit are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_auto_cs | input | 1 | 1: select follows transmit activity; 0: select follows the select bit |
| cfg_auto_start | input | 1 | 1: shift whenever data is present; 0: shift only after a start pulse |
| cfg_half_div | input | DIVW | Serial clock half period minus one, in system clocks |
| cs_we | input | 1 | Write strobe for the manual select bit |
| cs_val | input | 1 | Value written to the manual select bit (1 = select) |
| start_req | input | 1 | Manual start strobe |
| abort_req | input | 1 | Abort command |
| tx_push | input | 1 | Push tx_data into the transmit FIFO (ignored when full) |
| tx_data | input | WORD | Transmit word |
| tx_full | output | 1 | Transmit FIFO full |
| tx_level | output | CW | Transmit FIFO occupancy |
| rx_pop | input | 1 | Pop the head of the receive FIFO |
| rx_data | output | WORD | Head of the receive FIFO |
| rx_level | output | CW | Receive FIFO occupancy |
| tx_wm_we | input | 1 | Write wm_val into the transmit watermark |
| rx_wm_we | input | 1 | Write wm_val into the receive watermark |
| wm_val | input | CW | Watermark value |
| irq_en | input | 5 | Interrupt enable mask |
| irq_clr | input | 5 | Write-one-to-clear for the sticky status bits |
| irq_status | output | 5 | Status vector: 0 tx below watermark, 1 rx not empty, 2 rx at watermark, 3 rx overrun, 4 tx underflow |
| irq | output | 1 | Masked interrupt |
| busy | output | 1 | Shift engine active |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
Two things can land in one cycle here. A sticky status bit can be set by its event while software writes one to clear it. In the bench, a start strobe is driven on an empty transmit FIFO in the same cycle as the clear bit for underflow. The run is judged correct when the bit is still set the next cycle and drops only after a later clear on its own. A second case is a receive word that arrives while the FIFO is full: it is provoked by sending nine words with nobody popping. The FIFO must keep exactly its first eight words in order while the overrun bit rises.

// File: rtl/spim_pkg.sv
package spim_pkg;

    typedef enum logic [1:0] {
        EN_IDLE = 2'd0,
        EN_LOW  = 2'd1,
        EN_HIGH = 2'd2
    } eng_state_t;

    localparam int ST_TXLOW = 0;
    localparam int ST_RXNE  = 1;
    localparam int ST_RXWM  = 2;
    localparam int ST_RXOVR = 3;
    localparam int ST_TXUDF = 4;
    localparam int ST_W     = 5;

    localparam int FIFO_TX  = 0;
    localparam int FIFO_RX  = 1;
    localparam int FIFO_N   = 2;

endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count
);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic          push_ok, pop_ok;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign push_ok = push && (count != CW'(DEPTH));
    assign pop_ok  = pop && (count != '0);
    assign dout    = mem[rp_q];

    always_ff @(posedge clk) begin
        if (push_ok && !flush) begin
            mem[wp_q] <= din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            count <= '0;
        end else if (flush) begin
            wp_q  <= '0;
            rp_q  <= '0;
            count <= '0;
        end else begin
            if (push_ok) begin
                wp_q <= bump(wp_q);
            end
            if (pop_ok) begin
                rp_q <= bump(rp_q);
            end
            count <= count + CW'(push_ok) - CW'(pop_ok);
        end
    end

endmodule

// File: rtl/spim_engine.sv
module spim_engine
    import spim_pkg::*;
#(
    parameter int WORD = 32,
    parameter int DIVW = 8,
    localparam int BCW = $clog2(WORD)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            abort,
    input  logic            auto_start,
    input  logic            start,
    input  logic [DIVW-1:0] half_div,
    input  logic            tx_empty,
    input  logic [WORD-1:0] tx_word,
    input  logic            miso,
    output logic            tx_pop,
    output logic            rx_push,
    output logic [WORD-1:0] rx_word,
    output logic            start_empty,
    output logic            sclk,
    output logic            mosi,
    output logic            busy
);

    eng_state_t      state_q, state_d;
    logic [DIVW-1:0] div_q;
    logic [BCW-1:0]  bit_q;
    logic [WORD-1:0] sh_q, cap_q;
    logic            run_q;
    logic            go, half_done, load, word_end, last_bit;

    assign go        = auto_start || run_q || start;
    assign half_done = (div_q == half_div);
    assign last_bit  = (bit_q == BCW'(WORD - 1));

    // next-state logic
    always_comb begin
        state_d  = state_q;
        load     = 1'b0;
        word_end = 1'b0;
        unique case (state_q)
            EN_IDLE: begin
                if (go && !tx_empty) begin
                    state_d = EN_LOW;
                    load    = 1'b1;
                end
            end
            EN_LOW: begin
                if (half_done) begin
                    state_d = EN_HIGH;
                end
            end
            EN_HIGH: begin
                if (half_done) begin
                    if (last_bit) begin
                        word_end = 1'b1;
                        if (go && !tx_empty) begin
                            state_d = EN_LOW;
                            load    = 1'b1;
                        end else begin
                            state_d = EN_IDLE;
                        end
                    end else begin
                        state_d = EN_LOW;
                    end
                end
            end
            default: state_d = EN_IDLE;
        endcase
        if (abort) begin
            state_d  = EN_IDLE;
            load     = 1'b0;
            word_end = 1'b0;
        end
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= EN_IDLE;
            div_q   <= '0;
            bit_q   <= '0;
            sh_q    <= '0;
            cap_q   <= '0;
            run_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (abort || state_q == EN_IDLE || half_done) begin
                div_q <= '0;
            end else begin
                div_q <= div_q + 1'b1;
            end
            if (load) begin
                sh_q  <= tx_word;
                bit_q <= '0;
            end else if (state_q == EN_HIGH && half_done && !last_bit) begin
                sh_q  <= sh_q << 1;
                bit_q <= bit_q + 1'b1;
            end
            if (state_q == EN_LOW && half_done) begin
                cap_q <= {cap_q[WORD-2:0], miso};
            end
            if (abort) begin
                run_q <= 1'b0;
            end else if (word_end && state_d == EN_IDLE) begin
                run_q <= 1'b0;
            end else if (start && !tx_empty) begin
                run_q <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        tx_pop      = load;
        rx_push     = word_end;
        rx_word     = cap_q;
        start_empty = start && !abort && tx_empty && (state_q == EN_IDLE);
        sclk        = (state_q == EN_HIGH);
        busy        = (state_q != EN_IDLE);
        mosi        = (state_q != EN_IDLE) ? sh_q[WORD-1] : 1'b0;
    end

endmodule

// File: rtl/spim_status.sv
module spim_status
    import spim_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            abort,
    input  logic            tx_wm_we,
    input  logic            rx_wm_we,
    input  logic [CW-1:0]   wm_val,
    input  logic [CW-1:0]   tx_level,
    input  logic [CW-1:0]   rx_level,
    input  logic            ovr_evt,
    input  logic            udf_evt,
    input  logic [ST_W-1:0] clr,
    input  logic [ST_W-1:0] en,
    output logic [ST_W-1:0] status,
    output logic            irq
);

    logic [CW-1:0] tx_wm_q, rx_wm_q;
    logic          ovr_q, udf_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_wm_q <= CW'(1);
            rx_wm_q <= CW'(1);
            ovr_q   <= 1'b0;
            udf_q   <= 1'b0;
        end else begin
            if (abort) begin
                tx_wm_q <= CW'(1);
                rx_wm_q <= CW'(1);
            end else begin
                if (tx_wm_we) tx_wm_q <= wm_val;
                if (rx_wm_we) rx_wm_q <= wm_val;
            end
            ovr_q <= (ovr_q && !clr[ST_RXOVR]) || ovr_evt;
            udf_q <= (udf_q && !clr[ST_TXUDF]) || udf_evt;
        end
    end

    always_comb begin
        status           = '0;
        status[ST_TXLOW] = (tx_level < tx_wm_q);
        status[ST_RXNE]  = (rx_level != '0);
        status[ST_RXWM]  = (rx_level >= rx_wm_q);
        status[ST_RXOVR] = ovr_q;
        status[ST_TXUDF] = udf_q;
        irq              = |(status & en);
    end

endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
    import spim_pkg::*;
#(
    parameter int WORD  = 32,
    parameter int DEPTH = 8,
    parameter int DIVW  = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_auto_cs,
    input  logic            cfg_auto_start,
    input  logic [DIVW-1:0] cfg_half_div,
    input  logic            cs_we,
    input  logic            cs_val,
    input  logic            start_req,
    input  logic            abort_req,
    input  logic            tx_push,
    input  logic [WORD-1:0] tx_data,
    output logic            tx_full,
    output logic [CW-1:0]   tx_level,
    input  logic            rx_pop,
    output logic [WORD-1:0] rx_data,
    output logic [CW-1:0]   rx_level,
    input  logic            tx_wm_we,
    input  logic            rx_wm_we,
    input  logic [CW-1:0]   wm_val,
    input  logic [ST_W-1:0] irq_en,
    input  logic [ST_W-1:0] irq_clr,
    output logic [ST_W-1:0] irq_status,
    output logic            irq,
    output logic            busy,
    output logic            spi_sclk,
    output logic            spi_cs_n,
    output logic            spi_mosi,
    input  logic            spi_miso
);

    logic [FIFO_N-1:0] f_push, f_pop;
    logic [WORD-1:0]   f_din  [FIFO_N];
    logic [WORD-1:0]   f_dout [FIFO_N];
    logic [CW-1:0]     f_cnt  [FIFO_N];

    logic              eng_tx_pop, eng_rx_push, eng_start_empty;
    logic [WORD-1:0]   eng_rx_word;
    logic              man_cs_q, cs_n_q, cs_act;

    assign f_push[FIFO_TX] = tx_push;
    assign f_din[FIFO_TX]  = tx_data;
    assign f_pop[FIFO_TX]  = eng_tx_pop;
    assign f_push[FIFO_RX] = eng_rx_push;
    assign f_din[FIFO_RX]  = eng_rx_word;
    assign f_pop[FIFO_RX]  = rx_pop;

    for (genvar g = 0; g < FIFO_N; g++) begin : g_fifo
        spim_fifo #(.W(WORD), .DEPTH(DEPTH)) u_fifo (
            .clk   (clk),
            .rst_n (rst_n),
            .flush (abort_req),
            .push  (f_push[g]),
            .din   (f_din[g]),
            .pop   (f_pop[g]),
            .dout  (f_dout[g]),
            .count (f_cnt[g])
        );
    end

    assign tx_level = f_cnt[FIFO_TX];
    assign rx_level = f_cnt[FIFO_RX];
    assign rx_data  = f_dout[FIFO_RX];
    assign tx_full  = (f_cnt[FIFO_TX] == CW'(DEPTH));

    spim_engine #(.WORD(WORD), .DIVW(DIVW)) u_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .abort       (abort_req),
        .auto_start  (cfg_auto_start),
        .start       (start_req),
        .half_div    (cfg_half_div),
        .tx_empty    (f_cnt[FIFO_TX] == '0),
        .tx_word     (f_dout[FIFO_TX]),
        .miso        (spi_miso),
        .tx_pop      (eng_tx_pop),
        .rx_push     (eng_rx_push),
        .rx_word     (eng_rx_word),
        .start_empty (eng_start_empty),
        .sclk        (spi_sclk),
        .mosi        (spi_mosi),
        .busy        (busy)
    );

    spim_status #(.DEPTH(DEPTH)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .abort    (abort_req),
        .tx_wm_we (tx_wm_we),
        .rx_wm_we (rx_wm_we),
        .wm_val   (wm_val),
        .tx_level (f_cnt[FIFO_TX]),
        .rx_level (f_cnt[FIFO_RX]),
        .ovr_evt  (eng_rx_push && (f_cnt[FIFO_RX] == CW'(DEPTH))),
        .udf_evt  (eng_start_empty),
        .clr      (irq_clr),
        .en       (irq_en),
        .status   (irq_status),
        .irq      (irq)
    );

    // chip select: FIFO-driven or register-driven
    assign cs_act = cfg_auto_cs ? ((f_cnt[FIFO_TX] != '0) || busy) : man_cs_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            man_cs_q <= 1'b0;
            cs_n_q   <= 1'b1;
        end else if (abort_req) begin
            man_cs_q <= 1'b0;
            cs_n_q   <= 1'b1;
        end else begin
            if (cs_we) man_cs_q <= cs_val;
            cs_n_q <= !cs_act;
        end
    end

    assign spi_cs_n = cs_n_q;

endmodule

// File: rtl/spim_checker.sv
module spim_checker
    import spim_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cfg_auto_cs,
    input logic            cfg_auto_start,
    input logic            start_req,
    input logic            abort_req,
    input logic [ST_W-1:0] irq_clr,
    input logic [ST_W-1:0] irq_status,
    input logic [CW-1:0]   tx_level,
    input logic [CW-1:0]   rx_level,
    input logic            busy,
    input logic            spi_sclk,
    input logic            spi_cs_n,
    input logic            man_cs_q,
    input logic            eng_rx_push
);

    p_auto_cs_active_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_auto_cs && $past(cfg_auto_cs) && busy && $past(busy)) |-> !spi_cs_n);

    p_auto_cs_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_auto_cs && $past(cfg_auto_cs) && $past(!busy) && $past(tx_level == '0)) |-> spi_cs_n);

    p_manual_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_auto_cs && $past(!cfg_auto_cs) && $past(!abort_req)) |-> (spi_cs_n == !$past(man_cs_q)));

    p_stall_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && tx_level == '0) |=> !busy);

    p_sclk_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !spi_sclk);

    p_manual_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_auto_start && !busy && !start_req) |=> !busy);

    p_overrun_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_rx_push && rx_level == CW'(DEPTH)) |=> irq_status[ST_RXOVR]);

    p_rx_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_level <= CW'(DEPTH));

    p_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_req && !busy && tx_level == '0 && !abort_req) |=> irq_status[ST_TXUDF]);

    p_sticky_ovr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(irq_status[ST_RXOVR]) && !$past(irq_clr[ST_RXOVR])) |-> irq_status[ST_RXOVR]);

    p_sticky_udf_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(irq_status[ST_TXUDF]) && !$past(irq_clr[ST_TXUDF])) |-> irq_status[ST_TXUDF]);

    p_abort_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
        abort_req |=> (tx_level == '0 && rx_level == '0 && spi_cs_n));

endmodule

bind spi_fifo_master spim_checker #(.DEPTH(DEPTH)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_auto_cs    (cfg_auto_cs),
    .cfg_auto_start (cfg_auto_start),
    .start_req      (start_req),
    .abort_req      (abort_req),
    .irq_clr        (irq_clr),
    .irq_status     (irq_status),
    .tx_level       (tx_level),
    .rx_level       (rx_level),
    .busy           (busy),
    .spi_sclk       (spi_sclk),
    .spi_cs_n       (spi_cs_n),
    .man_cs_q       (man_cs_q),
    .eng_rx_push    (eng_rx_push)
);

// File: tb/test_spi_fifo_master.sv
`timescale 1ns/1ps
module test_spi_fifo_master;

    localparam int WORD  = 32;
    localparam int DEPTH = 8;
    localparam int DIVW  = 8;
    localparam int CW    = $clog2(DEPTH + 1);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cfg_auto_cs = 1'b1, cfg_auto_start = 1'b1;
    logic [DIVW-1:0] cfg_half_div = 8'd1;
    logic            cs_we = 1'b0, cs_val = 1'b0, start_req = 1'b0, abort_req = 1'b0;
    logic            tx_push = 1'b0, rx_pop = 1'b0, tx_wm_we = 1'b0, rx_wm_we = 1'b0;
    logic [WORD-1:0] tx_data = '0;
    logic [CW-1:0]   wm_val = '0;
    logic [4:0]      irq_en = '0, irq_clr = '0;
    logic            tx_full, irq, busy, spi_sclk, spi_cs_n, spi_mosi;
    logic            s_miso = 1'b0;
    logic [CW-1:0]   tx_level, rx_level;
    logic [WORD-1:0] rx_data;
    logic [4:0]      irq_status;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] exp_tx[$];
    logic [31:0] exp_rx[$];

    always #2.5 clk = ~clk;

    spi_fifo_master #(.WORD(WORD), .DEPTH(DEPTH), .DIVW(DIVW)) i_spi_fifo_master (
        .clk(clk), .rst_n(rst_n), .cfg_auto_cs(cfg_auto_cs), .cfg_auto_start(cfg_auto_start),
        .cfg_half_div(cfg_half_div), .cs_we(cs_we), .cs_val(cs_val), .start_req(start_req),
        .abort_req(abort_req), .tx_push(tx_push), .tx_data(tx_data), .tx_full(tx_full),
        .tx_level(tx_level), .rx_pop(rx_pop), .rx_data(rx_data), .rx_level(rx_level),
        .tx_wm_we(tx_wm_we), .rx_wm_we(rx_wm_we), .wm_val(wm_val), .irq_en(irq_en),
        .irq_clr(irq_clr), .irq_status(irq_status), .irq(irq), .busy(busy),
        .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(s_miso)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("[TB] FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] gen_word(input int n);
        return 32'h13579BDF ^ (32'(n) * 32'h9E3779B9);
    endfunction

    // slave model and monitor
    logic        cs_prev = 1'b1, sclk_prev = 1'b0, need_load = 1'b0;
    logic [31:0] s_out = '0, s_word = '0, s_in = '0;
    int          s_bits = 0, s_gen = 0;

    always @(spi_sclk or spi_cs_n) begin
        if (spi_cs_n === 1'b1) begin
            s_bits = 0;
            s_miso = 1'b0;
        end else if (spi_cs_n === 1'b0 && cs_prev === 1'b1) begin
            s_word = gen_word(s_gen); s_gen++;
            s_out = s_word; s_bits = 0; need_load = 1'b0;
            s_miso = s_out[31];
        end else if (spi_cs_n === 1'b0 && spi_sclk && !sclk_prev) begin
            s_in = {s_in[30:0], spi_mosi};
            s_bits++;
            if (s_bits == 32) begin
                s_bits = 0;
                if (exp_tx.size() == 0) begin
                    chk("R1 unexpected serial word", s_in, 32'hxxxxxxxx);
                end else begin
                    chk("R1 serial word out", s_in, exp_tx.pop_front());
                end
                exp_rx.push_back(s_word);
                need_load = 1'b1;
            end
        end else if (spi_cs_n === 1'b0 && !spi_sclk && sclk_prev) begin
            if (need_load) begin
                s_word = gen_word(s_gen); s_gen++;
                s_out = s_word; need_load = 1'b0;
            end else begin
                s_out = s_out << 1;
            end
            s_miso = s_out[31];
        end
        cs_prev   = spi_cs_n;
        sclk_prev = spi_sclk;
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push_word(input logic [31:0] w);
        while (tx_full) @(negedge clk);
        tx_push = 1'b1; tx_data = w;
        exp_tx.push_back(w);
        @(negedge clk);
        tx_push = 1'b0;
    endtask

    task automatic wait_idle();
        int guard = 0;
        @(negedge clk);
        while ((busy || tx_level != 0) && guard < 20000) begin
            @(negedge clk); guard++;
        end
    endtask

    task automatic pop_check(input string req);
        if (rx_level == 0 || exp_rx.size() == 0) begin
            chk({req, " rx word available"}, 32'(rx_level), 32'd1);
        end else begin
            chk(req, rx_data, exp_rx.pop_front());
        end
        rx_pop = 1'b1;
        @(negedge clk);
        rx_pop = 1'b0;
    endtask

    task automatic pulse_start();
        start_req = 1'b1; @(negedge clk); start_req = 1'b0;
    endtask

    task automatic set_cs(input logic v);
        cs_we = 1'b1; cs_val = v; @(negedge clk); cs_we = 1'b0;
    endtask

    task automatic do_abort();
        abort_req = 1'b1; @(negedge clk); abort_req = 1'b0;
        exp_tx.delete(); exp_rx.delete();
    endtask

    task automatic measure_bit(output int cyc);
        cyc = 0;
        while (!spi_sclk) @(negedge clk);
        while (spi_sclk) begin @(negedge clk); cyc++; end
        while (!spi_sclk) begin @(negedge clk); cyc++; end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("[TB] FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        int per;
        cycles(3);
        rst_n = 1'b1;
        cycles(2);

        // reset state
        chk("R2 reset cs_n", 32'(spi_cs_n), 32'd1);
        chk("R4 reset sclk", 32'(spi_sclk), 32'd0);
        chk("R12 reset busy", 32'(busy), 32'd0);
        chk("R7 reset status", 32'(irq_status), 32'h01);
        chk("R13 reset irq", 32'(irq), 32'd0);

        // auto select, auto start
        push_word(32'h80000001);
        push_word(32'hA5C30F96);
        push_word(32'h0123CDEF);
        measure_bit(per);
        chk("R11 bit period half_div=1", 32'(per), 32'd4);
        chk("R2 cs_n low while shifting", 32'(spi_cs_n), 32'd0);
        chk("R12 busy while shifting", 32'(busy), 32'd1);
        while (tx_level != 0) @(negedge clk);
        cycles(1);
        chk("R12 busy held between words", 32'(busy), 32'd1);
        wait_idle();
        chk("R12 busy low after drain", 32'(busy), 32'd0);
        cycles(1);
        chk("R2 cs_n released after drain", 32'(spi_cs_n), 32'd1);
        pop_check("R1 rx word 0");
        pop_check("R1 rx word 1");
        pop_check("R1 rx word 2");

        // manual select, auto start
        cfg_auto_cs = 1'b0;
        set_cs(1'b1);
        cycles(2);
        chk("R3 cs_n low on select bit", 32'(spi_cs_n), 32'd0);
        push_word(32'hDEADBEEF);
        wait_idle();
        cycles(3);
        chk("R3 cs_n held with empty fifo", 32'(spi_cs_n), 32'd0);
        chk("R4 stalled sclk low", 32'(spi_sclk), 32'd0);
        chk("R4 stalled busy low", 32'(busy), 32'd0);
        push_word(32'h5A5A0FF0);
        wait_idle();
        pop_check("R4 rx after stall a");
        pop_check("R4 rx after stall b");

        // manual start
        cfg_auto_start = 1'b0;
        push_word(32'h11112222);
        push_word(32'h33334444);
        cycles(20);
        chk("R5 no shift before strobe busy", 32'(busy), 32'd0);
        chk("R5 no shift before strobe level", 32'(tx_level), 32'd2);
        pulse_start();
        cycles(1);
        chk("R5 shifting after strobe", 32'(busy), 32'd1);
        wait_idle();
        push_word(32'h55556666);
        cycles(20);
        chk("R5 stopped after drain level", 32'(tx_level), 32'd1);
        chk("R5 stopped after drain busy", 32'(busy), 32'd0);
        pulse_start();
        wait_idle();
        pop_check("R5 rx 0");
        pop_check("R5 rx 1");
        pop_check("R5 rx 2");

        // underflow and same-cycle set/clear
        irq_en = 5'b10000;
        pulse_start();
        chk("R8 underflow set", 32'(irq_status[4]), 32'd1);
        chk("R13 irq from underflow", 32'(irq), 32'd1);
        chk("R8 no shift on empty strobe", 32'(busy), 32'd0);
        irq_clr = 5'b10000; @(negedge clk); irq_clr = 5'b00000;
        chk("R9 underflow cleared", 32'(irq_status[4]), 32'd0);
        chk("R13 irq dropped", 32'(irq), 32'd0);
        start_req = 1'b1; irq_clr = 5'b10000;
        @(negedge clk);
        start_req = 1'b0; irq_clr = 5'b00000;
        chk("R9 set wins over clear", 32'(irq_status[4]), 32'd1);
        irq_clr = 5'b10000; @(negedge clk); irq_clr = 5'b00000;
        chk("R9 clear alone", 32'(irq_status[4]), 32'd0);
        irq_en = 5'b00000;

        // watermarks
        wm_val = 4'd3; tx_wm_we = 1'b1; @(negedge clk); tx_wm_we = 1'b0;
        wm_val = 4'd2; rx_wm_we = 1'b1; @(negedge clk); rx_wm_we = 1'b0;
        push_word(32'hCAFE0001);
        push_word(32'hCAFE0002);
        chk("R7 tx below watermark", 32'(irq_status[0]), 32'd1);
        push_word(32'hCAFE0003);
        chk("R7 tx at watermark", 32'(irq_status[0]), 32'd0);
        pulse_start();
        wait_idle();
        chk("R7 rx not empty", 32'(irq_status[1]), 32'd1);
        chk("R7 rx at watermark", 32'(irq_status[2]), 32'd1);
        pop_check("R7 rx 0");
        chk("R7 rx level 2 at watermark", 32'(irq_status[2]), 32'd1);
        pop_check("R7 rx 1");
        chk("R7 rx level 1 below watermark", 32'(irq_status[2]), 32'd0);
        chk("R7 rx level 1 not empty", 32'(irq_status[1]), 32'd1);
        pop_check("R7 rx 2");
        chk("R7 rx empty", 32'(irq_status[1]), 32'd0);

        // abort
        wm_val = 4'd3;
        tx_wm_we = 1'b1; rx_wm_we = 1'b1; @(negedge clk); tx_wm_we = 1'b0; rx_wm_we = 1'b0;
        push_word(32'h0BADF00D);
        pulse_start();
        wait_idle();
        push_word(32'h77778888);
        push_word(32'h9999AAAA);
        do_abort();
        chk("R10 tx flushed", 32'(tx_level), 32'd0);
        chk("R10 rx flushed", 32'(rx_level), 32'd0);
        chk("R10 cs released", 32'(spi_cs_n), 32'd1);
        push_word(32'h12345678);
        chk("R10 tx watermark back to 1", 32'(irq_status[0]), 32'd0);
        set_cs(1'b1);
        cycles(1);
        pulse_start();
        wait_idle();
        chk("R10 rx watermark back to 1", 32'(irq_status[2]), 32'd1);
        pop_check("R10 rx after abort");

        // overrun
        cfg_auto_cs = 1'b1; cfg_auto_start = 1'b1;
        set_cs(1'b0);
        irq_en = 5'b01000;
        for (int i = 0; i < DEPTH + 1; i++) push_word(32'hF0000000 + 32'(i * 7));
        wait_idle();
        cycles(1);
        chk("R6 rx level capped", 32'(rx_level), 32'(DEPTH));
        chk("R6 overrun set", 32'(irq_status[3]), 32'd1);
        chk("R13 irq from overrun", 32'(irq), 32'd1);
        for (int i = 0; i < DEPTH; i++) pop_check("R6 kept word");
        exp_rx.delete();
        irq_clr = 5'b01000; @(negedge clk); irq_clr = 5'b00000;
        chk("R9 overrun cleared", 32'(irq_status[3]), 32'd0);
        irq_en = 5'b00000;

        // divider
        cfg_half_div = 8'd3;
        push_word(32'h6C6C3939);
        measure_bit(per);
        chk("R11 bit period half_div=3", 32'(per), 32'd8);
        wait_idle();
        pop_check("R11 rx word");

        // manual select bit low: shifting does not touch cs
        cfg_auto_cs = 1'b0;
        cycles(2);
        push_word(32'h0F0F0F0F);
        while (!busy) @(negedge clk);
        chk("R3 cs_n stays high while shifting", 32'(spi_cs_n), 32'd1);
        wait_idle();
        do_abort();

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule